// File: doc/BRIEF.md
# Flash Overlay RAM Address Remapper

This block decodes the 24-bit address of a microcontroller bus and steers each access to the flash array, to a 512-byte RAM bank, or to neither. The RAM bank always answers at its own fixed range, 0xFFF000 to 0xFFF1FF. When overlay is enabled, the same RAM cells also answer in one selectable 512-byte window of the small-block flash region, 0x01F000 to 0x01FFFF. Firmware can then adjust data that would normally live in flash, in real time, without an erase or program cycle.

An 8-bit control register holds the overlay state. Its bit 3 enables the overlay. Its bits 2 to 0 give the window number n, and window n starts at 0x01F000 + n*0x200. Bit 7 is a read-only error flag, set by a strobe from the flash controller. Bits 6 to 4 have no function. A hardware-standby input clears the register's live bits. A software-standby input leaves them unchanged. The address decode is combinational. A register write becomes visible to the decode starting with the next cycle.

Top module: `flash_overlay_remap`

## Requirements
- R1: Any address from 0xFFF000 to 0xFFF1FF asserts ramSel, drives ramOffset with address bits 8:0, and keeps flashSel low, whatever the register holds.
- R2: While register bit 3 is 0, every address from 0x01F000 to 0x01FFFF asserts flashSel and not ramSel, whatever bits 2:0 hold.
- R3: While bit 3 is 1 and bits 2:0 hold n, every address from 0x01F000+n*0x200 to 0x01F1FF+n*0x200 asserts ramSel with ramOffset equal to address bits 8:0, and keeps flashSel low.
- R4: While the overlay is enabled, the addresses in 0x01F000 to 0x01FFFF that lie outside the selected window still assert flashSel and not ramSel.
- R5: Addresses outside both ranges assert neither select, and ramOffset reads 0 whenever ramSel is low.
- R6: After reset the register reads 0x70.
- R7: A write changes only bits 3:0 of the register. Bits 6:4 always read 1, and bit 7 ignores the written value.
- R8: A pulse on errSet sets bit 7, and the flag stays set through later register writes.
- R9: A cycle with hwStandby high clears bit 7 and bits 3:0, so the register reads 0x70 in the next cycle. This clear takes priority over a write or errSet in the same cycle.
- R10: swStandby has no effect on the register contents or on the decode.
- R11: flashSel and ramSel are never high together.
- R12: A write takes effect on the decode starting with the cycle after the clock edge that captures it. Before that edge the decode follows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwStandby | input | 1 | Hardware standby; clears bit 7 and bits 3:0 of the register |
| swStandby | input | 1 | Software standby; the register keeps its values |
| errSet | input | 1 | Strobe from the flash controller that sets the error flag |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 8 | Data for a control register write |
| regRdData | output | 8 | Read-back value of the control register |
| busAddr | input | 24 | Bus address of the current access |
| flashSel | output | 1 | The access goes to the flash array |
| ramSel | output | 1 | The access goes to the overlay RAM bank |
| ramOffset | output | 9 | Byte offset of the access inside the RAM bank |

## Verification
Several properties are checked on every cycle. The two selects are never high together. The RAM offset equals the low address bits whenever ramSel is high. With the overlay disabled, the small-block region always decodes to flash. In the register, a write lands in the low nibble, the error flag is sticky, the hardware-standby clear wins, and software standby leaves the contents unchanged. Other behaviours need the bench's scenarios. These are the exact boundaries of each of the eight windows, the flash and unmapped addresses around them, the read-back pattern with its constant bits, and the cycle in which a new window selection first reaches the decode.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int WIN_SEL_W = 3;
  localparam int REG_W     = 8;

  typedef struct packed {
    logic                 overlayEn;
    logic [WIN_SEL_W-1:0] winSel;
  } remapCfg_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwStandby,
  input  logic             swStandby,
  input  logic             errSet,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output remapCfg_t        cfg
);
  localparam int LIVE_W  = WIN_SEL_W + 1;
  localparam int SPARE_W = REG_W - LIVE_W - 1;

  logic [LIVE_W-1:0] liveBits;
  logic              errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveBits <= '0;
      errFlag  <= 1'b0;
    end else if (hwStandby) begin
      liveBits <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (regWrEn) liveBits <= regWrData[LIVE_W-1:0];
      if (errSet)  errFlag  <= 1'b1;
    end
  end

  assign regRdData     = {errFlag, {SPARE_W{1'b1}}, liveBits};
  assign cfg.overlayEn = liveBits[LIVE_W-1];
  assign cfg.winSel    = liveBits[WIN_SEL_W-1:0];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !hwStandby) |=> (regRdData[LIVE_W-1:0] == $past(regWrData[LIVE_W-1:0]))) // R7
    else $error("write did not land");
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[REG_W-1] && !hwStandby) |=> regRdData[REG_W-1]) // R8
    else $error("error flag dropped");
  AST_HWSTBY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (regRdData == {1'b0, {SPARE_W{1'b1}}, {LIVE_W{1'b0}}})) // R9
    else $error("standby clear failed");
  AST_SWSTBY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !regWrEn && !hwStandby && !errSet) |=> $stable(regRdData)) // R10
    else $error("register changed in software standby");
endmodule

// File: rtl/remap_decode.sv
module remap_decode
  import remap_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          OFF_W      = 9,
  parameter logic [23:0] RAM_BASE   = 24'hFFF000,
  parameter logic [23:0] FLASH_BASE = 24'h01F000
) (
  input  logic              clk,
  input  logic              rstN,
  input  remapCfg_t         cfg,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              flashSel,
  output logic              ramSel,
  output logic [OFF_W-1:0]  ramOffset
);
  localparam int WIN_COUNT = 1 << WIN_SEL_W;
  localparam int REGION_LO = OFF_W + WIN_SEL_W;
  localparam logic [ADDR_W-1:0] RAM_B   = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] FLASH_B = ADDR_W'(FLASH_BASE);

  logic                 inNative;
  logic                 inRegion;
  logic [WIN_SEL_W-1:0] winIdx;
  logic [WIN_COUNT-1:0] winHit;
  logic                 overlayHit;

  assign inNative = (busAddr[ADDR_W-1:OFF_W] == RAM_B[ADDR_W-1:OFF_W]);
  assign inRegion = (busAddr[ADDR_W-1:REGION_LO] == FLASH_B[ADDR_W-1:REGION_LO]);
  assign winIdx   = busAddr[REGION_LO-1:OFF_W];

  for (genvar w = 0; w < WIN_COUNT; w++) begin : gWin
    assign winHit[w] = cfg.overlayEn && inRegion
                     && (cfg.winSel == WIN_SEL_W'(w)) && (winIdx == WIN_SEL_W'(w));
  end

  assign overlayHit = |winHit;
  assign ramSel     = inNative || overlayHit;
  assign flashSel   = inRegion && !overlayHit;
  assign ramOffset  = ramSel ? busAddr[OFF_W-1:0] : '0;

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(flashSel && ramSel)) // R11
    else $error("both selects high");
  AST_OFFSET_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> (ramOffset == busAddr[OFF_W-1:0])) // R3
    else $error("offset mismatch");
  AST_DISABLED_FLASH: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.overlayEn && busAddr[ADDR_W-1:REGION_LO] == FLASH_B[ADDR_W-1:REGION_LO]) |-> flashSel) // R2
    else $error("disabled overlay remapped");
  AST_WINDOW_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winHit)) // R3
    else $error("several windows hit");
endmodule

// File: rtl/flash_overlay_remap.sv
module flash_overlay_remap
  import remap_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          OFF_W      = 9,
  parameter logic [23:0] RAM_BASE   = 24'hFFF000,
  parameter logic [23:0] FLASH_BASE = 24'h01F000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              errSet,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              flashSel,
  output logic              ramSel,
  output logic [OFF_W-1:0]  ramOffset
);
  remapCfg_t cfg;

  remap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .errSet(errSet), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cfg(cfg)
  );

  remap_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .RAM_BASE(RAM_BASE), .FLASH_BASE(FLASH_BASE)
  ) uDecode (
    .clk(clk), .rstN(rstN), .cfg(cfg), .busAddr(busAddr),
    .flashSel(flashSel), .ramSel(ramSel), .ramOffset(ramOffset)
  );
endmodule

// File: tb/tb_flash_overlay_remap.sv
module tb_flash_overlay_remap;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hwStandby = 1'b0, swStandby = 1'b0, errSet = 1'b0, regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [23:0] busAddr = '0;
  logic        flashSel, ramSel;
  logic [8:0]  ramOffset;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  flash_overlay_remap dut (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .errSet(errSet), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .busAddr(busAddr), .flashSel(flashSel), .ramSel(ramSel), .ramOffset(ramOffset)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected decode: {flashSel, ramSel, ramOffset}
  task automatic expectDecode(string req, logic [23:0] a, logic f, logic r);
    busAddr = a;
    #1;
    chk(req, {21'd0, flashSel, ramSel, ramOffset}, {21'd0, f, r, (r ? a[8:0] : 9'd0)});
  endtask

  task automatic writeReg(logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic tReset;
    chk("R6 reset readback", regRdData, 8'h70);
    expectDecode("R2 reset no overlay", 24'h01F000, 1'b1, 1'b0);
  endtask

  task automatic tNativeRam;
    expectDecode("R1 native low", 24'hFFF000, 1'b0, 1'b1);
    expectDecode("R1 native high", 24'hFFF1FF, 1'b0, 1'b1);
    writeReg(8'h0D);
    expectDecode("R1 native with overlay", 24'hFFF0A5, 1'b0, 1'b1);
  endtask

  task automatic tDisabled;
    writeReg(8'h07);
    expectDecode("R2 disabled sel7", 24'h01FE10, 1'b1, 1'b0);
    expectDecode("R2 disabled top", 24'h01FFFF, 1'b1, 1'b0);
  endtask

  task automatic tWindows;
    for (int n = 0; n < 8; n++) begin
      logic [23:0] base;
      base = 24'h01F000 + 24'(n) * 24'h200;
      writeReg(8'h08 | 8'(n));
      expectDecode("R3 window start", base, 1'b0, 1'b1);
      expectDecode("R3 window end", base + 24'h1FF, 1'b0, 1'b1);
      expectDecode("R4 other window", 24'h01F000 + 24'((n + 3) % 8) * 24'h200 + 24'h44, 1'b1, 1'b0);
      if (n > 0) expectDecode("R4 just below", base - 24'h1, 1'b1, 1'b0);
      if (n < 7) expectDecode("R4 just above", base + 24'h200, 1'b1, 1'b0);
    end
  endtask

  task automatic tOutside;
    expectDecode("R5 below region", 24'h01EFFF, 1'b0, 1'b0);
    expectDecode("R5 above region", 24'h020000, 1'b0, 1'b0);
    expectDecode("R5 above native", 24'hFFF200, 1'b0, 1'b0);
    expectDecode("R5 zero", 24'h000000, 1'b0, 1'b0);
    expectDecode("R5 below native", 24'hFFEFFF, 1'b0, 1'b0);
  endtask

  task automatic tWriteMask;
    writeReg(8'hF5);
    chk("R7 write mask", regRdData, 8'h75);
    writeReg(8'h0A);
    chk("R7 write low nibble", regRdData, 8'h7A);
  endtask

  task automatic tErrFlag;
    @(negedge clk); errSet = 1'b1;
    @(negedge clk); errSet = 1'b0;
    chk("R8 flag set", regRdData, 8'hFA);
    writeReg(8'h03);
    chk("R8 flag survives write", regRdData, 8'hF3);
  endtask

  task automatic tHwStandby;
    writeReg(8'h0B);
    @(negedge clk); hwStandby = 1'b1; regWrEn = 1'b1; regWrData = 8'h0F; errSet = 1'b1;
    @(negedge clk); hwStandby = 1'b0; regWrEn = 1'b0; errSet = 1'b0;
    chk("R9 hw standby clear", regRdData, 8'h70);
    expectDecode("R9 overlay off after standby", 24'h01F600, 1'b1, 1'b0);
  endtask

  task automatic tSwStandby;
    writeReg(8'h0C);
    @(negedge clk); swStandby = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 sw standby keeps", regRdData, 8'h7C);
    expectDecode("R10 decode kept", 24'h01F800, 1'b0, 1'b1);
    swStandby = 1'b0;
  endtask

  task automatic tTiming;
    writeReg(8'h08);
    @(negedge clk); regWrEn = 1'b1; regWrData = 8'h0E;
    expectDecode("R12 old window before edge", 24'h01F000, 1'b0, 1'b1);
    expectDecode("R12 new window before edge", 24'h01FC00, 1'b1, 1'b0);
    @(negedge clk); regWrEn = 1'b0;
    expectDecode("R12 new window after edge", 24'h01FC00, 1'b0, 1'b1);
    expectDecode("R12 old window after edge", 24'h01F000, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNativeRam();
    tDisabled();
    tWindows();
    tOutside();
    tWriteMask();
    tErrFlag();
    tHwStandby();
    tSwStandby();
    tTiming();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule